// File: doc/BRIEF.md
# Four-Stage Load Pipeline Controller

This block steers load requests through a four-stage execution pipeline (s0 to s3). It carries an age tag and a few per-load flags through the stages and exchanges only control with its surroundings. In s0 it accepts a request and starts the address translation and the cache lookup in the same cycle. In s1 it takes the translated physical address and may kill the load. In s2 it takes the cache hit/miss and the two memory-ordering results, and may send an early wakeup to dependent instructions. In s3 it either writes back or asks for a replay, and in both cases it updates the load queue.

Translation, the cache and the ordering checks are represented by plain response inputs. Each response is valid in the cycle its load sits in the matching stage. An MMIO load follows its own route. It wakes its consumers at acceptance, uses no cache lookup, ignores the hit indication and still delivers its data in s3. A redirect carrying an age flushes every stage that holds a younger load. Backpressure from the writeback side ripples back stage by stage to the request input.

Top module: `ldpipe_ctrl`

## Requirements
- R1: When a request is accepted (in_valid_i high, in_ready_o high, not flushed by a redirect), tlb_req_o is high in that same cycle with tlb_vaddr_o equal to in_vaddr_i. dc_req_o is also high in that cycle unless in_mmio_i is set.
- R2: An accepted MMIO load raises mmio_wake_o with mmio_wake_age_o equal to its age in the acceptance cycle. It never raises fast_wake_o. Its dc_hit_i value is ignored, so it is treated as a hit, and it still reaches s3.
- R3: One cycle after acceptance, s1_kill_o is high if the load has the fast-replay flag and s1_fast_match_i is low, or has the load-to-load flag and s1_l2l_ok_i is low, or a redirect is active whose age is older than the load. A killed load never appears in s3. A load without a flag is not affected by the matching s1 input.
- R4: With no stall, s3 outputs hold a load three cycles after its acceptance. lq_upd_paddr_o is the tlb_paddr_i value from its s1 cycle, and wb_data_o (128 bits) is the dc_data_i value from its s2 cycle.
- R5: The replay cause is taken from the s2 inputs with this priority. Miss (dc_hit_i low, non-MMIO) gives code 1. Read-after-write failure (raw_ok_i low) gives code 2. Read-after-read failure (rar_ok_i low) gives code 3. No failure gives code 0.
- R6: fast_wake_o is high two cycles after acceptance, with fast_wake_age_o equal to the load's age, for a non-MMIO load that hits in s2 and moves into s3 in that cycle. It is high regardless of the ordering results.
- R7: In s3, a load with cause 0 drives wb_valid_o high and lq_upd_replay_o low. Any other cause drives wb_valid_o low, lq_upd_replay_o high and lq_upd_cause_o equal to the code. lq_upd_valid_o is high when s3 holds an unflushed load and wb_ready_i is high.
- R8: A load is younger than the redirect when (age - redirect_age) mod 2^AGE_W lies in 1 to 2^(AGE_W-1)-1. While redirect_valid_i is high, younger loads in s1 to s3 are removed, and a younger request at the input is dropped with no tlb_req_o. Loads of equal or older age are kept.
- R9: A stage advances only when the next stage is empty or advancing. While wb_ready_i is low, s3 keeps its load and outputs. in_ready_o falls once s1, s2 and s3 are all occupied. Loads leave in acceptance order.
- R10: After reset, wb_valid_o, lq_upd_valid_o, fast_wake_o and s1_kill_o are low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Load request present |
| in_ready_o | output | 1 | s1 can take a request |
| in_age_i | input | AGE_W | Age tag of the request |
| in_vaddr_i | input | VADDR_W | Virtual address |
| in_mmio_i | input | 1 | Load is MMIO |
| in_fast_i | input | 1 | Load is a fast replay |
| in_l2l_i | input | 1 | Load uses load-to-load forwarding |
| tlb_req_o | output | 1 | Translation request |
| tlb_vaddr_o | output | VADDR_W | Address to translate |
| dc_req_o | output | 1 | Cache lookup request |
| mmio_wake_o | output | 1 | Early wakeup for an MMIO load |
| mmio_wake_age_o | output | AGE_W | Age of the MMIO wakeup |
| tlb_paddr_i | input | PADDR_W | Physical address for the s1 load |
| s1_fast_match_i | input | 1 | Fast-replay address match for the s1 load |
| s1_l2l_ok_i | input | 1 | Load-to-load forward success for the s1 load |
| s1_kill_o | output | 1 | s1 load is killed |
| dc_hit_i | input | 1 | Cache hit for the s2 load |
| dc_data_i | input | DATA_W | Cache data for the s2 load |
| raw_ok_i | input | 1 | Read-after-write check passed |
| rar_ok_i | input | 1 | Read-after-read check passed |
| fast_wake_o | output | 1 | Early wakeup from s2 |
| fast_wake_age_o | output | AGE_W | Age of the s2 wakeup |
| redirect_valid_i | input | 1 | Redirect active |
| redirect_age_i | input | AGE_W | Age of the redirecting instruction |
| wb_ready_i | input | 1 | Writeback side can take the s3 load |
| wb_valid_o | output | 1 | Writeback valid |
| wb_age_o | output | AGE_W | Age of the s3 load |
| wb_data_o | output | DATA_W | Writeback data |
| lq_upd_valid_o | output | 1 | Load-queue update this cycle |
| lq_upd_replay_o | output | 1 | Update requests a replay |
| lq_upd_cause_o | output | 2 | Replay cause code |
| lq_upd_paddr_o | output | PADDR_W | Physical address of the s3 load |

## Verification
The assertions take for granted three things about the inputs. Each response input is valid in the cycle its load occupies s1 or s2, and it is held while that stage is stalled. All ages in flight and the redirect age lie within half the age space of one another, so the circular comparison stays meaningful. A redirect pulse is aligned to the cycles in which its effects are sampled. The bench meets these conditions as follows. It drives each response in the matching stage cycle. It holds the responses constant during backpressure phases. It keeps the in-flight ages within a short window, except in the one directed case that crosses the wrap point on purpose.

// File: rtl/ldpipe_pkg.sv
package ldpipe_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_MISS = 2'd1,
    CAUSE_RAW  = 2'd2,
    CAUSE_RAR  = 2'd3
  } replay_cause_e;

  typedef struct packed {
    logic mmio;
    logic fast;
    logic l2l;
  } ld_flags_t;

  localparam int FLAGS_W = $bits(ld_flags_t);
  localparam int CAUSE_W = $bits(replay_cause_e);
endpackage

// File: rtl/ldpipe_stage_reg.sv
module ldpipe_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         v_i,
  input  logic [W-1:0] d_i,
  input  logic         drop_i,
  output logic         v_o,
  output logic [W-1:0] d_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o <= 1'b0;
    end else if (load_i) begin
      v_o <= v_i;
    end else if (drop_i) begin
      v_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_o <= '0;
    end else if (load_i && v_i) begin
      d_o <= d_i;
    end
  end

  // R9
  hold_when_stalled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !drop_i) |=> ($stable(v_o) && $stable(d_o)));
endmodule

// File: rtl/ldpipe_age_flush.sv
module ldpipe_age_flush #(
  parameter int AGE_W = 6,
  parameter int NUM   = 4
) (
  input  logic                      redir_v_i,
  input  logic [AGE_W-1:0]          redir_age_i,
  input  logic [NUM-1:0][AGE_W-1:0] age_i,
  output logic [NUM-1:0]            flush_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    logic [AGE_W-1:0] diff;
    // circular distance: nonzero and under half the age space means younger
    assign diff       = age_i[g] - redir_age_i;
    assign flush_o[g] = redir_v_i && (diff != '0) && !diff[AGE_W-1];
  end
endmodule

// File: rtl/ldpipe_s1_kill.sv
module ldpipe_s1_kill
  import ldpipe_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      s1_v_i,
  input  ld_flags_t flags_i,
  input  logic      fast_match_i,
  input  logic      l2l_ok_i,
  input  logic      flush_i,
  output logic      kill_o
);
  logic fast_bad, l2l_bad;

  assign fast_bad = flags_i.fast && !fast_match_i;
  assign l2l_bad  = flags_i.l2l && !l2l_ok_i;
  assign kill_o   = s1_v_i && (fast_bad || l2l_bad || flush_i);

  // R3
  kill_needs_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_o |-> s1_v_i);
endmodule

// File: rtl/ldpipe_s2_resolve.sv
module ldpipe_s2_resolve
  import ldpipe_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          s2_v_i,
  input  logic          mmio_i,
  input  logic          flush_i,
  input  logic          adv_i,
  input  logic          dc_hit_i,
  input  logic          raw_ok_i,
  input  logic          rar_ok_i,
  output replay_cause_e cause_o,
  output logic          fast_wake_o
);
  logic hit_eff;

  // MMIO bypasses the cache, so its hit input is meaningless
  assign hit_eff = mmio_i || dc_hit_i;

  always_comb begin
    if (!hit_eff)       cause_o = CAUSE_MISS;
    else if (!raw_ok_i) cause_o = CAUSE_RAW;
    else if (!rar_ok_i) cause_o = CAUSE_RAR;
    else                cause_o = CAUSE_NONE;
  end

  assign fast_wake_o = s2_v_i && adv_i && !flush_i && !mmio_i && dc_hit_i;

  // R5
  wake_not_on_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_wake_o |-> (cause_o != CAUSE_MISS));

  // R2
  mmio_no_fast_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_v_i && mmio_i) |-> !fast_wake_o);
endmodule

// File: rtl/ldpipe_ctrl.sv
module ldpipe_ctrl
  import ldpipe_pkg::*;
#(
  parameter int AGE_W   = 6,
  parameter int VADDR_W = 39,
  parameter int PADDR_W = 36,
  parameter int DATA_W  = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [AGE_W-1:0]   in_age_i,
  input  logic [VADDR_W-1:0] in_vaddr_i,
  input  logic               in_mmio_i,
  input  logic               in_fast_i,
  input  logic               in_l2l_i,
  output logic               tlb_req_o,
  output logic [VADDR_W-1:0] tlb_vaddr_o,
  output logic               dc_req_o,
  output logic               mmio_wake_o,
  output logic [AGE_W-1:0]   mmio_wake_age_o,
  input  logic [PADDR_W-1:0] tlb_paddr_i,
  input  logic               s1_fast_match_i,
  input  logic               s1_l2l_ok_i,
  output logic               s1_kill_o,
  input  logic               dc_hit_i,
  input  logic [DATA_W-1:0]  dc_data_i,
  input  logic               raw_ok_i,
  input  logic               rar_ok_i,
  output logic               fast_wake_o,
  output logic [AGE_W-1:0]   fast_wake_age_o,
  input  logic               redirect_valid_i,
  input  logic [AGE_W-1:0]   redirect_age_i,
  input  logic               wb_ready_i,
  output logic               wb_valid_o,
  output logic [AGE_W-1:0]   wb_age_o,
  output logic [DATA_W-1:0]  wb_data_o,
  output logic               lq_upd_valid_o,
  output logic               lq_upd_replay_o,
  output logic [1:0]         lq_upd_cause_o,
  output logic [PADDR_W-1:0] lq_upd_paddr_o
);
  localparam int NSTG = 4;
  localparam int S1_W = AGE_W + FLAGS_W;
  localparam int S2_W = AGE_W + 1 + PADDR_W;
  localparam int S3_W = AGE_W + PADDR_W + CAUSE_W + DATA_W;

  logic [NSTG-1:0][AGE_W-1:0] stg_age;
  logic [NSTG-1:0]            flush;

  logic s1_v, s2_v, s3_v;
  logic s1_free, s2_free, s3_free;
  logic s0_take, s1_kill, s3_out;

  logic [S1_W-1:0] s1_d;
  logic [S2_W-1:0] s2_d;
  logic [S3_W-1:0] s3_d;

  ld_flags_t        in_fl, s1_fl;
  logic [AGE_W-1:0] s1_age, s2_age, s3_age;
  logic             s2_mmio;
  logic [PADDR_W-1:0] s2_pa, s3_pa;
  replay_cause_e    s2_cause, s3_cause;
  logic [DATA_W-1:0] s3_data;

  // ready chain: a stage is free if empty or its successor is free
  assign s3_free    = !s3_v || wb_ready_i;
  assign s2_free    = !s2_v || s3_free;
  assign s1_free    = !s1_v || s2_free;
  assign in_ready_o = s1_free;

  assign stg_age[0] = in_age_i;
  assign stg_age[1] = s1_age;
  assign stg_age[2] = s2_age;
  assign stg_age[3] = s3_age;

  ldpipe_age_flush #(.AGE_W(AGE_W), .NUM(NSTG)) u_flush (
    .redir_v_i   (redirect_valid_i),
    .redir_age_i (redirect_age_i),
    .age_i       (stg_age),
    .flush_o     (flush)
  );

  // s0
  assign in_fl           = '{mmio: in_mmio_i, fast: in_fast_i, l2l: in_l2l_i};
  assign s0_take         = in_valid_i && s1_free && !flush[0];
  assign tlb_req_o       = s0_take;
  assign tlb_vaddr_o     = in_vaddr_i;
  assign dc_req_o        = s0_take && !in_mmio_i;
  assign mmio_wake_o     = s0_take && in_mmio_i;
  assign mmio_wake_age_o = in_age_i;

  // s1
  ldpipe_stage_reg #(.W(S1_W)) u_s1 (
    .clk_i, .rst_ni,
    .load_i (s1_free),
    .v_i    (s0_take),
    .d_i    ({in_age_i, in_fl}),
    .drop_i (s1_kill),
    .v_o    (s1_v),
    .d_o    (s1_d)
  );
  assign {s1_age, s1_fl} = s1_d;

  ldpipe_s1_kill u_kill (
    .clk_i, .rst_ni,
    .s1_v_i       (s1_v),
    .flags_i      (s1_fl),
    .fast_match_i (s1_fast_match_i),
    .l2l_ok_i     (s1_l2l_ok_i),
    .flush_i      (flush[1]),
    .kill_o       (s1_kill)
  );
  assign s1_kill_o = s1_kill;

  // s2
  ldpipe_stage_reg #(.W(S2_W)) u_s2 (
    .clk_i, .rst_ni,
    .load_i (s2_free),
    .v_i    (s1_v && !s1_kill),
    .d_i    ({s1_age, s1_fl.mmio, tlb_paddr_i}),
    .drop_i (flush[2]),
    .v_o    (s2_v),
    .d_o    (s2_d)
  );
  assign {s2_age, s2_mmio, s2_pa} = s2_d;

  ldpipe_s2_resolve u_res (
    .clk_i, .rst_ni,
    .s2_v_i      (s2_v),
    .mmio_i      (s2_mmio),
    .flush_i     (flush[2]),
    .adv_i       (s3_free),
    .dc_hit_i    (dc_hit_i),
    .raw_ok_i    (raw_ok_i),
    .rar_ok_i    (rar_ok_i),
    .cause_o     (s2_cause),
    .fast_wake_o (fast_wake_o)
  );
  assign fast_wake_age_o = s2_age;

  // s3
  ldpipe_stage_reg #(.W(S3_W)) u_s3 (
    .clk_i, .rst_ni,
    .load_i (s3_free),
    .v_i    (s2_v && !flush[2]),
    .d_i    ({s2_age, s2_pa, s2_cause, dc_data_i}),
    .drop_i (flush[3]),
    .v_o    (s3_v),
    .d_o    (s3_d)
  );
  assign s3_age   = s3_d[S3_W-1 -: AGE_W];
  assign s3_pa    = s3_d[DATA_W+CAUSE_W +: PADDR_W];
  assign s3_cause = replay_cause_e'(s3_d[DATA_W +: CAUSE_W]);
  assign s3_data  = s3_d[DATA_W-1:0];

  assign s3_out          = s3_v && !flush[3];
  assign wb_valid_o      = s3_out && (s3_cause == CAUSE_NONE);
  assign wb_age_o        = s3_age;
  assign wb_data_o       = s3_data;
  assign lq_upd_valid_o  = s3_out && wb_ready_i;
  assign lq_upd_replay_o = (s3_cause != CAUSE_NONE);
  assign lq_upd_cause_o  = s3_cause;
  assign lq_upd_paddr_o  = s3_pa;

  // R1
  dc_with_tlb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_req_o |-> tlb_req_o);

  // R2
  mmio_no_cache_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmio_wake_o |-> !dc_req_o);

  // R6
  wake_lands_in_s3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_wake_o |=> (s3_v && (wb_age_o == $past(fast_wake_age_o))));

  // R7
  wb_is_clean_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && wb_ready_i) |-> (lq_upd_valid_o && !lq_upd_replay_o));

  // R8
  flushed_s3_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_valid_i && flush[3]) |-> (!wb_valid_o && !lq_upd_valid_o));

  // R9
  s3_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s3_v && !wb_ready_i && !redirect_valid_i) |=> (s3_v && $stable(wb_age_o)));
endmodule

// File: tb/ldpipe_ctrl_test.sv
`timescale 1ns/1ps
module ldpipe_ctrl_test;
  localparam int AGE_W = 6, VADDR_W = 39, PADDR_W = 36, DATA_W = 128;
  localparam int NVEC = 13;
  // {mmio,fast,fast_ok,l2l,l2l_ok,hit,raw_ok,rar_ok, exp_kill,exp_fw,exp_wb,exp_cause[1:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b0_0_1_0_1_1_1_1_0_1_1_00,  // clean hit
    13'b0_0_1_0_1_0_1_1_0_0_0_01,  // miss
    13'b0_0_1_0_1_1_0_1_0_1_0_10,  // raw fail
    13'b0_0_1_0_1_1_1_0_0_1_0_11,  // rar fail
    13'b0_0_1_0_1_0_0_0_0_0_0_01,  // all fail: miss wins
    13'b0_0_1_0_1_1_0_0_0_1_0_10,  // raw beats rar
    13'b0_1_0_0_1_1_1_1_1_0_0_00,  // fast replay mismatch
    13'b0_1_1_0_1_1_1_1_0_1_1_00,  // fast replay match
    13'b0_0_1_1_0_1_1_1_1_0_0_00,  // l2l fail
    13'b0_0_1_1_1_1_1_1_0_1_1_00,  // l2l ok
    13'b1_0_1_0_1_0_1_1_0_0_1_00,  // mmio, miss ignored
    13'b1_0_1_0_1_1_0_1_0_0_0_10,  // mmio raw fail
    13'b0_0_0_0_0_1_1_1_0_1_1_00   // no flags, bad s1 inputs ignored
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_mmio = 0, in_fast = 0, in_l2l = 0;
  logic [AGE_W-1:0] in_age = '0, redir_age = '0;
  logic [VADDR_W-1:0] in_vaddr = '0;
  logic [PADDR_W-1:0] paddr = '0;
  logic fast_ok = 1, l2l_ok = 1, hit = 1, raw_ok = 1, rar_ok = 1;
  logic [DATA_W-1:0] dc_data = '0;
  logic redir_v = 0, wb_ready = 1;
  logic in_ready, tlb_req, dc_req, mmio_wake, s1_kill, fast_wake;
  logic [VADDR_W-1:0] tlb_vaddr;
  logic [AGE_W-1:0] mmio_wake_age, fast_wake_age, wb_age;
  logic wb_valid, lq_valid, lq_replay;
  logic [DATA_W-1:0] wb_data;
  logic [1:0] lq_cause;
  logic [PADDR_W-1:0] lq_paddr;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  ldpipe_ctrl #(.AGE_W(AGE_W), .VADDR_W(VADDR_W), .PADDR_W(PADDR_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_age_i(in_age), .in_vaddr_i(in_vaddr),
    .in_mmio_i(in_mmio), .in_fast_i(in_fast), .in_l2l_i(in_l2l),
    .tlb_req_o(tlb_req), .tlb_vaddr_o(tlb_vaddr), .dc_req_o(dc_req),
    .mmio_wake_o(mmio_wake), .mmio_wake_age_o(mmio_wake_age),
    .tlb_paddr_i(paddr), .s1_fast_match_i(fast_ok), .s1_l2l_ok_i(l2l_ok), .s1_kill_o(s1_kill),
    .dc_hit_i(hit), .dc_data_i(dc_data), .raw_ok_i(raw_ok), .rar_ok_i(rar_ok),
    .fast_wake_o(fast_wake), .fast_wake_age_o(fast_wake_age),
    .redirect_valid_i(redir_v), .redirect_age_i(redir_age), .wb_ready_i(wb_ready),
    .wb_valid_o(wb_valid), .wb_age_o(wb_age), .wb_data_o(wb_data),
    .lq_upd_valid_o(lq_valid), .lq_upd_replay_o(lq_replay), .lq_upd_cause_o(lq_cause),
    .lq_upd_paddr_o(lq_paddr)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic push(input logic [AGE_W-1:0] age);
    in_valid = 1; in_age = age; in_mmio = 0; in_fast = 0; in_l2l = 0;
    in_vaddr = VADDR_W'(age) << 4;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog actual=running expected=done");
    summary();
  end

  initial begin
    // R10 reset state
    #1;
    chk("R10 wb_valid", wb_valid, 0);
    chk("R10 lq_valid", lq_valid, 0);
    chk("R10 fast_wake", fast_wake, 0);
    chk("R10 s1_kill", s1_kill, 0);
    chk("R10 in_ready", in_ready, 1);
    cyc(); cyc(); rst_n = 1; cyc();

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      logic [12:0] v;
      logic [PADDR_W-1:0] exp_pa;
      logic [DATA_W-1:0] exp_d;
      v = VEC[i];
      exp_pa = PADDR_W'(36'h8_0000_0000 + 36'(i) * 36'h40);
      exp_d = {4{32'hA500_0000 + 32'(i)}};
      in_valid = 1; in_age = AGE_W'(i + 1); in_vaddr = VADDR_W'(i) * 39'h1000 + 39'h18;
      in_mmio = v[12]; in_fast = v[11]; in_l2l = v[9];
      #1;
      chk("R1 tlb_req", tlb_req, 1);
      chk("R1 tlb_vaddr", tlb_vaddr, in_vaddr);
      chk("R1 dc_req", dc_req, !v[12]);
      chk("R2 mmio_wake", mmio_wake, v[12]);
      if (v[12]) chk("R2 mmio_wake_age", mmio_wake_age, AGE_W'(i + 1));
      cyc();
      in_valid = 0; fast_ok = v[10]; l2l_ok = v[8]; paddr = exp_pa;
      #1;
      chk("R3 s1_kill", s1_kill, v[4]);
      cyc();
      fast_ok = 1; l2l_ok = 1; paddr = '0;
      hit = v[7]; raw_ok = v[6]; rar_ok = v[5]; dc_data = exp_d;
      #1;
      chk("R6 fast_wake", fast_wake, v[3]);
      if (v[3]) chk("R6 fast_wake_age", fast_wake_age, AGE_W'(i + 1));
      cyc();
      hit = 1; raw_ok = 1; rar_ok = 1; dc_data = '0;
      #1;
      chk("R3 lq_valid", lq_valid, !v[4]);
      chk("R7 wb_valid", wb_valid, v[2]);
      if (!v[4]) begin
        chk("R5 cause", lq_cause, v[1:0]);
        chk("R7 replay", lq_replay, v[1:0] != 2'd0);
        chk("R4 age", wb_age, AGE_W'(i + 1));
        chk("R4 paddr", lq_paddr, exp_pa);
        chk("R4 data", wb_data, exp_d);
      end
      cyc();
    end

    // R9 backpressure and ordering
    wb_ready = 0;
    push(20); cyc(); push(21); cyc(); push(22); cyc();
    push(23); #1;
    chk("R9 in_ready full", in_ready, 0);
    chk("R9 no tlb_req when full", tlb_req, 0);
    cyc(); cyc(); #1;
    chk("R9 s3 held age", wb_age, 20);
    chk("R9 s3 held wb_valid", wb_valid, 1);
    chk("R9 no lq update stalled", lq_valid, 0);
    wb_ready = 1; #1;
    chk("R9 release lq", lq_valid, 1);
    chk("R9 release accept", tlb_req, 1);
    cyc(); in_valid = 0; #1;
    chk("R9 order 21", wb_age, 21);
    cyc(); #1;
    chk("R9 order 22", wb_age, 22);
    cyc(); #1;
    chk("R9 order 23", wb_age, 23);
    chk("R9 order 23 valid", lq_valid, 1);
    cyc();

    // R8 flush of younger stages, equal age kept
    wb_ready = 0;
    push(10); cyc(); push(11); cyc(); push(12); cyc(); in_valid = 0;
    redir_v = 1; redir_age = 10; #1;
    chk("R8 s1 younger killed", s1_kill, 1);
    chk("R8 equal age kept", wb_valid, 1);
    cyc(); redir_v = 0; wb_ready = 1; #1;
    chk("R8 kept age", wb_age, 10);
    chk("R8 kept lq", lq_valid, 1);
    cyc(); #1;
    chk("R8 flushed s2 gone", lq_valid, 0);
    cyc(); #1;
    chk("R8 flushed s1 gone", lq_valid, 0);
    cyc(); #1;
    chk("R8 empty", lq_valid, 0);

    // R8 request at input younger is dropped, older accepted
    redir_v = 1; redir_age = 30; push(31); #1;
    chk("R8 younger input dropped", tlb_req, 0);
    push(29); #1;
    chk("R8 older input accepted", tlb_req, 1);
    cyc(); in_valid = 0; redir_v = 0;
    cyc(); cyc(); #1;
    chk("R8 older reaches s3", wb_age, 29);
    chk("R8 older reaches s3 valid", wb_valid, 1);
    cyc(); cyc(); cyc();

    // R8 wrap: age 1 vs redirect 62 -> distance 3, younger
    wb_ready = 0;
    push(1); cyc(); in_valid = 0; cyc(); cyc(); #1;
    chk("R8 wrap setup", wb_age, 1);
    redir_v = 1; redir_age = 62; #1;
    chk("R8 wrap younger flushed", wb_valid, 0);
    cyc(); redir_v = 0; #1;
    chk("R8 wrap stays flushed", wb_valid, 0);
    // age 40 vs redirect 62 -> distance 42, older
    push(40); cyc(); in_valid = 0; cyc(); cyc(); #1;
    redir_v = 1; redir_age = 62; #1;
    chk("R8 older kept during redirect", wb_valid, 1);
    cyc(); redir_v = 0; #1;
    chk("R8 older kept after redirect", wb_age, 40);
    wb_ready = 1; #1;
    chk("R8 older retires", lq_valid, 1);
    cyc(); cyc();

    summary();
  end
endmodule